// File: doc/BRIEF.md
# Programmable Oversampling Bit Timer

This block sets the bit time of a serial transmitter and receiver. It counts ticks of a baud-rate clock enable. A 4-bit oversampling code chooses how many ticks make up one bit, from 4 to 16. The transmitter side runs freely from reset. It raises a one-cycle bit strobe on the tick that ends each bit, and the shift logic outside uses that strobe to move to the next bit.

The receiver side stays idle until it gets a restart pulse. Framing logic outside sends that pulse when it sees a start edge. From then on the block raises a sample strobe in the middle of each bit: first after half a bit time, then once every full bit time. The same code sets the length of both sides. A change to the code never shortens or stretches a bit that is already running. Each side loads the new length only at its own bit boundary, or at a restart for the receiver.

Top module: `os_bit_timer`

## Requirements
- R1: After reset both strobes are low. The first transmit bit lasts 16 ticks. The sample strobe stays low until the first restart pulse.
- R2: Oversampling codes 0, 1, 2 and 3 each select 16 ticks per bit.
- R3: Codes 4 to 15 select exactly that many ticks per bit. For example, code 13 gives 13 ticks.
- R4: The bit strobe is high for one cycle. It is high only in a cycle where the baud tick is high, and only on every N-th tick, where N is the selected length.
- R5: After a restart, the sample strobe fires on tick floor(N/2). After that it fires once every N ticks.
- R6: The transmitter and the receiver take their lengths from the same code input.
- R7: A code change has no effect on the bit in progress. The transmitter loads the new length at the tick that ends the current bit. The receiver loads it at its next bit boundary or at a restart.
- R8: A restart clears the receive phase. A tick in the same cycle as the restart is not counted, and the sample strobe is low in that cycle. A restart has no effect on transmit timing.
- R9: Cycles without a baud tick do not advance either phase. Only ticks are counted, whatever the gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle enable, one per oversampling tick |
| osCode | input | 4 | Oversampling code: 0 to 3 give 16, 4 to 15 give that value |
| rxRestart | input | 1 | Start-edge pulse that realigns receive timing |
| bitStrobe | output | 1 | Transmit bit boundary, high on the last tick of a bit |
| sampleStrobe | output | 1 | Receive mid-bit sample point |

## Verification
A wrong phase count or a wrong latched length moves a strobe. The fault shows as a tick interval that differs from N or floor(N/2), at the latest within one bit time of the fault. The bench sweeps every code value with different gaps between ticks. It measures the interval to the next strobe in ticks and compares it with the arithmetic expectation. Length changes in mid-bit and restarts in mid-bit are also driven. A length loaded at the wrong moment shows as an interval that is a mix of the old and new lengths. A restart that leaks into the transmitter shows as a shortened transmit bit.

// File: rtl/osbt_pkg.sv
package osbt_pkg;
  // Commands from control to the phase counters: index 0 = transmit, 1 = receive
  typedef struct packed {
    logic rxClear;
    logic rxStep;
    logic txClear;
    logic txStep;
  } phaseCtl_t;
endpackage

// File: rtl/osbt_phase.sv
module osbt_phase #(
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  osbt_pkg::phaseCtl_t  ctl,
  output logic [CNT_W-1:0]     txPhase,
  output logic [CNT_W-1:0]     rxPhase
);
  localparam int LANES = 2;

  logic [LANES-1:0]            laneStep;
  logic [LANES-1:0]            laneClear;
  logic [LANES-1:0][CNT_W-1:0] lanePhase;

  assign laneStep  = {ctl.rxStep,  ctl.txStep};
  assign laneClear = {ctl.rxClear, ctl.txClear};
  assign txPhase   = lanePhase[0];
  assign rxPhase   = lanePhase[1];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lanePhase[g] <= '0;
      else if (laneClear[g])  lanePhase[g] <= '0;
      else if (laneStep[g])   lanePhase[g] <= lanePhase[g] + 1'b1;
    end

    AST_PHASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      laneClear[g] |=> (lanePhase[g] == '0)); // R8
    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!laneClear[g] && !laneStep[g]) |=> $stable(lanePhase[g])); // R9
  end
endmodule

// File: rtl/osbt_ctrl.sv
module osbt_ctrl #(
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 5,
  parameter int DEF_LEN = 16,
  parameter int MIN_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baudTick,
  input  logic [CODE_W-1:0]    osCode,
  input  logic                 rxRestart,
  input  logic [CNT_W-1:0]     txPhase,
  input  logic [CNT_W-1:0]     rxPhase,
  output osbt_pkg::phaseCtl_t  ctl,
  output logic                 bitStrobe,
  output logic                 sampleStrobe
);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0]  LEN_DEF  = CNT_W'(DEF_LEN);
  localparam logic [CNT_W-1:0]  LEN_MIN  = CNT_W'(MIN_LEN);
  localparam logic [CODE_W-1:0] CODE_MIN = CODE_W'(MIN_LEN);

  logic [CNT_W-1:0] decodedLen;
  logic [CNT_W-1:0] txLen;
  logic [CNT_W-1:0] rxLen;
  logic [CNT_W-1:0] rxHalf;
  logic             rxActive;
  logic             txWrap;
  logic             rxTick;
  logic             rxWrap;

  // Low codes alias to the default length
  always_comb begin
    if (osCode < CODE_MIN) decodedLen = LEN_DEF;
    else                   decodedLen = {{(CNT_W-CODE_W){1'b0}}, osCode};
  end

  assign rxHalf = rxLen >> 1;
  assign txWrap = baudTick && (txPhase == txLen - ONE);
  assign rxTick = rxActive && baudTick && !rxRestart;
  assign rxWrap = rxTick && (rxPhase == rxLen - ONE);

  assign bitStrobe    = txWrap;
  assign sampleStrobe = rxTick && (rxPhase == rxHalf - ONE);

  always_comb begin
    ctl.txClear = txWrap;
    ctl.txStep  = baudTick && !txWrap;
    ctl.rxClear = rxRestart || rxWrap;
    ctl.rxStep  = rxTick && !rxWrap;
  end

  // Transmit length loads only at a bit boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txLen <= LEN_DEF;
    else if (txWrap) txLen <= decodedLen;
  end

  // Receive length loads at restart or at a receive bit boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxLen    <= LEN_DEF;
      rxActive <= 1'b0;
    end else if (rxRestart) begin
      rxLen    <= decodedLen;
      rxActive <= 1'b1;
    end else if (rxWrap) begin
      rxLen    <= decodedLen;
    end
  end

  AST_TX_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (txLen >= LEN_MIN) && (txLen <= LEN_DEF)); // R3
  AST_TX_LEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txLen) |-> $past(bitStrobe)); // R7
  AST_RX_LEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rxLen) |-> ($past(rxRestart) || $past(ctl.rxClear))); // R7
  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bitStrobe |-> baudTick); // R4
  AST_NO_SAMPLE_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rxRestart |-> !sampleStrobe); // R8
  AST_SAMPLE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |-> rxActive); // R1
  AST_TX_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    txPhase < txLen); // R4
endmodule

// File: rtl/os_bit_timer.sv
module os_bit_timer #(
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 5,
  parameter int DEF_LEN = 16,
  parameter int MIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baudTick,
  input  logic [CODE_W-1:0] osCode,
  input  logic              rxRestart,
  output logic              bitStrobe,
  output logic              sampleStrobe
);
  osbt_pkg::phaseCtl_t ctl;
  logic [CNT_W-1:0]    txPhase;
  logic [CNT_W-1:0]    rxPhase;

  osbt_ctrl #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .DEF_LEN(DEF_LEN), .MIN_LEN(MIN_LEN)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .osCode(osCode),
    .rxRestart(rxRestart), .txPhase(txPhase), .rxPhase(rxPhase),
    .ctl(ctl), .bitStrobe(bitStrobe), .sampleStrobe(sampleStrobe)
  );

  osbt_phase #(.CNT_W(CNT_W)) uPhase (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .txPhase(txPhase), .rxPhase(rxPhase)
  );
endmodule

// File: tb/os_bit_timer_test.sv
module os_bit_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baudTick = 1'b0;
  logic [3:0] osCode = 4'd0;
  logic       rxRestart = 1'b0;
  logic       bitStrobe;
  logic       sampleStrobe;

  int checks = 0;
  int fails = 0;
  int gap = 0;
  bit sawBit;
  bit sawSample;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .osCode(osCode),
    .rxRestart(rxRestart), .bitStrobe(bitStrobe), .sampleStrobe(sampleStrobe)
  );

  function automatic int lenOf(input int code);
    return (code < 4) ? 16 : code;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One baud tick preceded by `gap` idle cycles; strobes sampled mid-cycle
  task automatic doTick();
    repeat (gap) @(negedge clk);
    @(negedge clk);
    baudTick = 1'b1;
    #1;
    sawBit = bitStrobe;
    sawSample = sampleStrobe;
    @(negedge clk);
    baudTick = 1'b0;
    #1;
    if (bitStrobe || sampleStrobe) check("R4 strobe without tick", 1, 0);
  endtask

  task automatic ticksToBit(output int n);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      doTick();
      n++;
      if (sawBit) break;
    end
  endtask

  task automatic ticksToSample(output int n);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      doTick();
      n++;
      if (sawSample) break;
    end
  endtask

  task automatic pulseRestart();
    @(negedge clk);
    rxRestart = 1'b1;
    @(negedge clk);
    rxRestart = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int n;
    int smp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 bitStrobe after reset", int'(bitStrobe), 0);
    check("R1 sampleStrobe after reset", int'(sampleStrobe), 0);

    // R1: first bit 16 ticks, no sample before restart
    osCode = 4'd7;
    smp = 0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      doTick();
      n++;
      if (sawSample) smp++;
      if (sawBit) break;
    end
    check("R1 first bit length", n, 16);
    check("R1 no sample before restart", smp, 0);

    // R2 R3 R5 R6 R9: sweep every code with varied gaps
    for (int c = 0; c < 16; c++) begin
      gap = c % 3;
      osCode = 4'(c);
      ticksToBit(n);               // finish bit in progress; new length loads
      ticksToBit(n);
      check((c < 4) ? "R2 tx bit length" : "R3 tx bit length", n, lenOf(c));
      ticksToBit(n);
      check("R4 tx bit length repeat", n, lenOf(c));
      pulseRestart();
      ticksToSample(n);
      check("R5 R6 first sample", n, lenOf(c) / 2);
      ticksToSample(n);
      check("R5 sample period", n, lenOf(c));
    end
    gap = 0;

    // R7 tx: change code mid-bit
    osCode = 4'd5;
    ticksToBit(n);
    ticksToBit(n);
    check("R3 len5", n, 5);
    doTick(); doTick();
    osCode = 4'd12;
    ticksToBit(n);
    check("R7 tx bit in progress keeps length", n, 3);
    ticksToBit(n);
    check("R7 tx new length at boundary", n, 12);

    // R7 rx: change code mid-bit
    osCode = 4'd8;
    pulseRestart();
    doTick(); doTick();
    osCode = 4'd14;
    ticksToSample(n);
    check("R7 rx first sample old length", n, 2);
    ticksToSample(n);
    check("R7 rx next sample after boundary", n, 4 + 7);

    // R8: restart with simultaneous tick
    osCode = 4'd10;
    pulseRestart();
    doTick(); doTick(); doTick();
    @(negedge clk);
    rxRestart = 1'b1;
    baudTick = 1'b1;
    #1;
    check("R8 no sample on restart cycle", int'(sampleStrobe), 0);
    @(negedge clk);
    rxRestart = 1'b0;
    baudTick = 1'b0;
    ticksToSample(n);
    check("R8 realigned first sample", n, 5);

    // R8: restart does not disturb transmit timing
    osCode = 4'd6;
    ticksToBit(n);
    ticksToBit(n);
    check("R3 len6", n, 6);
    doTick(); doTick();
    pulseRestart();
    ticksToBit(n);
    check("R8 tx unaffected by restart", n, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule